// File: doc/BRIEF.md
# Two-Dimensional DMA Address Walker

This block produces the element addresses for one DMA channel. Software writes a start address, an inner count and an inner step, an outer count and an outer step, and a control word through a small register write port. It then pulses `start`. The walker presents one address at a time on a valid/ready stream. It moves on only when the consumer takes the current address.

Within a row, each accepted element moves the address by the inner step. The last element of a row moves the address by the outer step instead. Both steps are signed and are scaled by the element size. Because the outer step may be smaller than the inner step, or negative, the walk can interleave or de-interleave data that sits in memory as rows.

An outer count of one gives a plain 1-D buffer. In stop mode the channel goes idle after the last element. In circular mode it returns to the start address, reloads both counts and carries on. A `done` pulse marks the end of each full buffer. The `irq` pulse fires at the end of each full buffer, and can also fire at the end of every row.

Top module: `dma2d_agen`

## Requirements
- R1: While reset is held and after it is released, `addr_valid`, `busy`, `done` and `irq` are low. The reset input is asynchronous and active low. Its release takes effect two clock edges later.
- R2: A `start` pulse while idle makes `busy` and `addr_valid` high from the next clock edge, and the first address equals the programmed start address.
- R3: Within a row, each accepted element advances the address by the signed inner step times the element size.
- R4: The accepted element that ends a row advances the address by the signed outer step times the element size. The outer step may be negative or smaller than the inner step.
- R5: A count of zero in either dimension means 65536 elements.
- R6: Control bits [1:0] select the element size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is also treated as 4 bytes.
- R7: While `addr_valid` is high and `addr_ready` is low, `addr_out` and `addr_valid` hold their values.
- R8: When control bit 2 is 0 (stop mode), accepting the last element of the buffer drops `addr_valid` and `busy` at the next edge. `done` is then high for exactly the following cycle.
- R9: When control bit 2 is 1 (circular mode), accepting the last element of the buffer puts the start address on `addr_out` at the next edge. Both counts reload, `busy` stays high, and `done` pulses.
- R10: `irq` is high for the one cycle after the buffer's last element is accepted. When control bit 3 is 1, it is also high for the one cycle after the last element of any row is accepted.
- R11: Register writes and `start` pulses while `busy` is high are ignored. The running walk and the next started walk both use the values held before the walk began.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 start address, 1 inner count, 2 inner step, 3 outer count, 4 outer step, 5 control |
| cfg_wdata | input | AW (32) | Register write data; counts and steps use the low 16 bits |
| start | input | 1 | Begin a walk when idle |
| busy | output | 1 | A walk is in progress |
| addr_valid | output | 1 | `addr_out` holds an address to be taken |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_out | output | AW (32) | Current element address |
| done | output | 1 | One-cycle pulse after a full buffer completes |
| irq | output | 1 | One-cycle interrupt pulse at buffer end, or at row end when enabled |

## Verification
The hardest case to reach from the ports is a count of zero. It stands for 65536, so it needs a full 65536-element walk in each dimension before the wrap can be seen. The stimulus holds `addr_ready` high for two such runs: one with a zero inner count and one with a zero outer count. It checks every address and the end pulses. A second hard case is a row end that coincides with a consumer stall. For this, a shift-register pattern drives `addr_ready` across a sweep of counts, signed step pairs and element sizes, so that stalls land on row boundaries and buffer ends.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    ESZ_B1  = 2'd0,
    ESZ_B2  = 2'd1,
    ESZ_B4  = 2'd2,
    ESZ_B4X = 2'd3
  } esz_e;

  typedef enum logic [2:0] {
    REG_BASE  = 3'd0,
    REG_ICNT  = 3'd1,
    REG_ISTEP = 3'd2,
    REG_OCNT  = 3'd3,
    REG_OSTEP = 3'd4,
    REG_CTRL  = 3'd5
  } reg_e;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_RUN  = 1'b1
  } wstate_e;

  // shift amount that turns an element step into a byte step
  function automatic logic [1:0] esz_shift(input esz_e e);
    case (e)
      ESZ_B1:  return 2'd0;
      ESZ_B2:  return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_cfg.sv
module dma2d_cfg
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          lock,
  output logic [AW-1:0] base,
  output logic [CW-1:0] icnt,
  output logic [SW-1:0] istep,
  output logic [CW-1:0] ocnt,
  output logic [SW-1:0] ostep,
  output esz_e          esz,
  output logic          circ,
  output logic          rowirq
);

  logic [AW-1:0] base_q, base_d;
  logic [CW-1:0] icnt_q, icnt_d, ocnt_q, ocnt_d;
  logic [SW-1:0] istep_q, istep_d, ostep_q, ostep_d;
  logic [3:0]    ctrl_q, ctrl_d;
  logic          wr_en;

  assign wr_en = we & ~lock;

  always_comb begin
    base_d  = base_q;
    icnt_d  = icnt_q;
    istep_d = istep_q;
    ocnt_d  = ocnt_q;
    ostep_d = ostep_q;
    ctrl_d  = ctrl_q;
    case (reg_e'(sel))
      REG_BASE:  base_d  = wdata;
      REG_ICNT:  icnt_d  = wdata[CW-1:0];
      REG_ISTEP: istep_d = wdata[SW-1:0];
      REG_OCNT:  ocnt_d  = wdata[CW-1:0];
      REG_OSTEP: ostep_d = wdata[SW-1:0];
      REG_CTRL:  ctrl_d  = wdata[3:0];
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      icnt_q  <= '0;
      istep_q <= '0;
      ocnt_q  <= '0;
      ostep_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      base_q  <= base_d;
      icnt_q  <= icnt_d;
      istep_q <= istep_d;
      ocnt_q  <= ocnt_d;
      ostep_q <= ostep_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign base   = base_q;
  assign icnt   = icnt_q;
  assign istep  = istep_q;
  assign ocnt   = ocnt_q;
  assign ostep  = ostep_q;
  assign esz    = esz_e'(ctrl_q[1:0]);
  assign circ   = ctrl_q[2];
  assign rowirq = ctrl_q[3];

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock && we |=> $stable(base_q) && $stable(icnt_q) && $stable(ocnt_q)
                   && $stable(istep_q) && $stable(ostep_q) && $stable(ctrl_q)); // R11

endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
  import dma2d_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] icnt_cfg,
  input  logic [CW-1:0] ocnt_cfg,
  input  logic          circ,
  input  logic          accept,
  output logic          busy,
  output logic          go,
  output logic          row_last,
  output logic          buf_last
);

  localparam logic [CW:0] CNT_ONE = (CW+1)'(1);

  function automatic logic [CW:0] expand(input logic [CW-1:0] c);
    return (c == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, c};
  endfunction

  wstate_e     st_q, st_d;
  logic [CW:0] icnt_q, icnt_d, ocnt_q, ocnt_d;
  logic        en;

  assign go       = (st_q == WS_IDLE) & start;
  assign row_last = (icnt_q == CNT_ONE);
  assign buf_last = row_last & (ocnt_q == CNT_ONE);
  assign en       = go | ((st_q == WS_RUN) & accept);

  always_comb begin
    st_d   = st_q;
    icnt_d = icnt_q;
    ocnt_d = ocnt_q;
    if (go) begin
      st_d   = WS_RUN;
      icnt_d = expand(icnt_cfg);
      ocnt_d = expand(ocnt_cfg);
    end else if (buf_last) begin
      if (circ) begin
        icnt_d = expand(icnt_cfg);
        ocnt_d = expand(ocnt_cfg);
      end else begin
        st_d = WS_IDLE;
      end
    end else if (row_last) begin
      icnt_d = expand(icnt_cfg);
      ocnt_d = ocnt_q - CNT_ONE;
    end else begin
      icnt_d = icnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WS_IDLE;
      icnt_q <= '0;
      ocnt_q <= '0;
    end else if (en) begin
      st_q   <= st_d;
      icnt_q <= icnt_d;
      ocnt_q <= ocnt_d;
    end
  end

  assign busy = (st_q == WS_RUN);

  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (icnt_q != '0) && (ocnt_q != '0)); // R5
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy); // R2
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && accept && buf_last && !circ |=> !busy); // R8
  AST_CIRC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && accept && buf_last && circ |=> busy); // R9

endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          accept,
  input  logic          row_last,
  input  logic          buf_last,
  input  logic          circ,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] istep,
  input  logic [SW-1:0] ostep,
  input  esz_e          esz,
  output logic [AW-1:0] addr
);

  localparam int EXT = AW - SW;

  logic [AW-1:0] addr_q, addr_d;
  logic [SW-1:0] step_sel;
  logic [AW-1:0] step_ext, step_bytes;
  logic [1:0]    sh;
  logic          en;

  assign sh         = esz_shift(esz);
  assign step_sel   = row_last ? ostep : istep;
  assign step_ext   = {{EXT{step_sel[SW-1]}}, step_sel};
  assign step_bytes = step_ext << sh;
  assign en         = go | (accept & ~(buf_last & ~circ));

  always_comb begin
    if (go || (buf_last && circ)) addr_d = base;
    else                           addr_d = addr_q + step_bytes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr_q <= '0;
    else if (en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !go |=> $stable(addr_q)); // R7

endmodule

// File: rtl/dma2d_evt.sv
module dma2d_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic row_last,
  input  logic buf_last,
  input  logic rowirq,
  output logic done,
  output logic irq
);

  logic done_q, done_d, irq_q, irq_d;

  always_comb begin
    done_d = accept & buf_last;
    irq_d  = accept & (buf_last | (row_last & rowirq));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign done = done_q;
  assign irq  = irq_q;

  AST_DONE_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> irq); // R10

endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          start,
  output logic          busy,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out,
  output logic          done,
  output logic          irq
);

  logic [1:0]    rst_sync_q;
  logic          rst_i;
  logic [AW-1:0] base_w;
  logic [CW-1:0] icnt_w, ocnt_w;
  logic [SW-1:0] istep_w, ostep_w;
  esz_e          esz_w;
  logic          circ_w, rowirq_w;
  logic          busy_w, go_w, row_last_w, buf_last_w, accept_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign accept_w = busy_w & addr_ready;

  dma2d_cfg #(.AW(AW), .CW(CW), .SW(SW)) u_cfg (
    .clk(clk), .rst_n(rst_i), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .lock(busy_w), .base(base_w), .icnt(icnt_w), .istep(istep_w),
    .ocnt(ocnt_w), .ostep(ostep_w), .esz(esz_w), .circ(circ_w), .rowirq(rowirq_w)
  );

  dma2d_walk #(.CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_i), .start(start), .icnt_cfg(icnt_w), .ocnt_cfg(ocnt_w),
    .circ(circ_w), .accept(accept_w), .busy(busy_w), .go(go_w),
    .row_last(row_last_w), .buf_last(buf_last_w)
  );

  dma2d_addr #(.AW(AW), .SW(SW)) u_addr (
    .clk(clk), .rst_n(rst_i), .go(go_w), .accept(accept_w), .row_last(row_last_w),
    .buf_last(buf_last_w), .circ(circ_w), .base(base_w), .istep(istep_w),
    .ostep(ostep_w), .esz(esz_w), .addr(addr_out)
  );

  dma2d_evt u_evt (
    .clk(clk), .rst_n(rst_i), .accept(accept_w), .row_last(row_last_w),
    .buf_last(buf_last_w), .rowirq(rowirq_w), .done(done), .irq(irq)
  );

  assign busy       = busy_w;
  assign addr_valid = busy_w;

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_i)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out)); // R7
  AST_BUF_END_PULSE: assert property (@(posedge clk) disable iff (!rst_i)
    accept_w && buf_last_w |=> done && irq); // R10
  AST_CIRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_i)
    accept_w && buf_last_w && circ_w |=> addr_out == $past(base_w)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_i |-> !addr_valid && !done && !irq); // R1

endmodule

// File: tb/sim_dma2d_agen.sv
module sim_dma2d_agen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        start;
  logic        busy, addr_valid, addr_ready, done, irq;
  logic [31:0] addr_out;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  dma2d_agen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_out(addr_out), .done(done), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    addr_ready = 1'b0; start = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk(!addr_valid && !busy && !done && !irq, "R1", {addr_valid, busy, done, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !busy && !done && !irq, "R1", {addr_valid, busy, done, irq}, 0);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_buf(input logic [31:0] base, input int ic, input int oc,
                         input int is, input int os, input int sz, input bit circ,
                         input bit rowirq, input int nbuf, input bit stall,
                         input string label);
    int sh;
    int col, row, left;
    logic [31:0] m_addr, hold_addr;
    bit hold, exp_irq, exp_done, row_end, buf_end;
    string tag;
    sh = (sz == 0) ? 0 : (sz == 1) ? 1 : 2;
    wr(0, base);
    wr(1, 32'(ic & 16'hFFFF));
    wr(2, 32'(is));
    wr(3, 32'(oc & 16'hFFFF));
    wr(4, 32'(os));
    wr(5, 32'(sz) | (circ ? 32'h4 : 32'h0) | (rowirq ? 32'h8 : 32'h0));
    pulse_start();
    m_addr = base; col = 0; row = 0; left = nbuf * ic * oc;
    hold = 0; exp_irq = 0; exp_done = 0;
    tag = (label != "") ? label : "R2";
    while (left > 0) begin
      if (exp_irq || irq) chk(irq == exp_irq, "R10", irq, exp_irq);
      if (exp_done || done) chk(done == exp_done, "R8", done, exp_done);
      if (hold) chk(addr_valid && addr_out == hold_addr, "R7", addr_out, hold_addr);
      if (!addr_valid) chk(0, "R2", 0, 1);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      addr_ready = stall ? lfsr[0] : 1'b1;
      hold = 0; exp_irq = 0; exp_done = 0;
      if (addr_valid && addr_ready) begin
        chk(addr_out == m_addr, tag, addr_out, m_addr);
        row_end = (col == ic - 1);
        buf_end = row_end && (row == oc - 1);
        exp_done = buf_end;
        exp_irq = buf_end || (row_end && rowirq);
        if (buf_end) begin
          m_addr = base; col = 0; row = 0; tag = "R9";
        end else if (row_end) begin
          m_addr = m_addr + (32'(os) << sh); col = 0; row++; tag = "R4";
        end else begin
          m_addr = m_addr + (32'(is) << sh); col++;
          tag = (sz != 0) ? "R6" : "R3";
        end
        if (label != "") tag = label;
        left--;
      end else if (addr_valid) begin
        hold = 1; hold_addr = addr_out;
      end
      @(negedge clk);
    end
    addr_ready = 1'b0;
    chk(irq == exp_irq, "R10", irq, exp_irq);
    chk(done == exp_done, "R8", done, exp_done);
    if (circ) begin
      chk(busy && addr_valid && addr_out == base, "R9", addr_out, base);
      do_reset();
    end else begin
      chk(!busy && !addr_valid, "R8", {busy, addr_valid}, 0);
      @(negedge clk);
      chk(!done && !irq, "R8", {done, irq}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int idx;
    int isv[4];
    int osv[4];
    isv = '{1, 2, -3, 4};
    osv = '{1, -5, 7, 1};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    start = 1'b0; addr_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(!addr_valid && !busy && !done && !irq, "R1", {addr_valid, busy, done, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!addr_valid && !busy && !done && !irq, "R1", {addr_valid, busy, done, irq}, 0);

    // sweep: sizes x counts x step pairs, stop mode
    idx = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int ic = 1; ic <= 3; ic++)
        for (int oc = 1; oc <= 3; oc++)
          for (int p = 0; p < 4; p++) begin
            run_buf(32'h0000_4000 + 32'(idx * 64), ic, oc, isv[p], osv[p], sz,
                    1'b0, idx[0], 1, idx[1], "");
            idx++;
          end

    // circular mode, two and three passes
    run_buf(32'h0001_0000, 3, 2, 2, -3, 1, 1'b1, 1'b1, 2, 1'b1, "");
    run_buf(32'h0002_0000, 2, 3, -1, 6, 2, 1'b1, 1'b0, 3, 1'b0, "");
    run_buf(32'hFFFF_FFF0, 4, 2, 3, -9, 3, 1'b1, 1'b1, 2, 1'b1, "");

    // R11: writes and start ignored while busy
    run_buf(32'h0000_1000, 4, 1, 1, 1, 0, 1'b0, 1'b0, 1, 1'b0, "");
    pulse_start();
    chk(addr_out == 32'h1000, "R11", addr_out, 32'h1000);
    addr_ready = 1'b1;
    @(negedge clk);
    addr_ready = 1'b0;
    chk(addr_out == 32'h1001, "R11", addr_out, 32'h1001);
    wr(0, 32'h0000_8000);
    wr(5, 32'h0000_0004);
    pulse_start();
    chk(addr_valid && addr_out == 32'h1001, "R11", addr_out, 32'h1001);
    addr_ready = 1'b1;
    repeat (3) @(negedge clk);
    addr_ready = 1'b0;
    chk(!busy, "R11", busy, 0);
    pulse_start();
    chk(addr_valid && addr_out == 32'h1000, "R11", addr_out, 32'h1000);
    addr_ready = 1'b1;
    repeat (4) @(negedge clk);
    addr_ready = 1'b0;
    chk(!busy, "R11", busy, 0);

    // R5: zero counts mean 65536
    run_buf(32'h0010_0000, 65536, 1, 1, 1, 0, 1'b0, 1'b0, 1, 1'b0, "R5");
    run_buf(32'h0020_0000, 1, 65536, 5, -1, 0, 1'b0, 1'b0, 1, 1'b0, "R5");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule